// File: doc/BRIEF.md
# Resumable NMI Trap and Return Controller

This block keeps the machine-level state for resumable non-maskable interrupts: a status register, an exception-PC register and a cause register. It orders two events. The first is taking an RNMI. The second is the matching return instruction, called mnret here. For each event it produces the redirect the core must follow: the next PC, the next privilege, the next virtualization mode and the next landing-pad expectation (ELP). ELP is the one-bit forward control-flow integrity state. It is 0 for "no landing pad expected" and 1 for "landing pad expected".

When an RNMI is taken, the block saves the interrupted ELP into a dedicated status bit, but only if landing pads are enabled for the interrupted privilege. It then forces ELP to 0. On mnret, the saved bit becomes the new ELP only if landing pads are enabled for the privilege being returned to. The saved bit is cleared on every return. A synchronous exception taken while the RNMI handler runs also saves ELP into that same bit. Software reads and writes the three registers through a small select-based CSR port. Instruction decode and the ordinary machine trap registers sit outside the block.

Top module: `rnmi_ctrl`

## Requirements
- R1: After synchronous reset, the status register reads 0x1808 (enable bit set, previous privilege = machine). The exception-PC and cause registers read 0.
- R2: The status register (csr_sel = 0) has these fields: enable bit 3, previous-virtualization bit 7, saved-ELP bit 9, previous privilege bits 12:11. Every other bit reads 0 and ignores writes. A write whose bits 12:11 hold the reserved value 2 leaves the previous-privilege field unchanged.
- R3: Bit 0 of the exception-PC register (csr_sel = 1) is always 0, both after CSR writes and after RNMI entry.
- R4: When nmi_req is high, mnret_req is low and the enable bit is 1, the same cycle shows redirect = 1, nxt_pc = rnmi_vec, nxt_priv = 3, nxt_virt = 0 and nxt_elp = 0. From the next cycle on: the exception-PC register holds cur_pc with bit 0 cleared, the cause register (csr_sel = 2) holds nmi_cause, the previous privilege field holds cur_priv, the previous-virtualization bit holds cur_virt, and the enable bit is 0.
- R5: On RNMI entry, the saved-ELP bit takes cur_elp when lpe_en[cur_priv] is 1. Otherwise the bit keeps its value.
- R6: An RNMI request is ignored while the enable bit is 0: redirect stays 0 and the registers do not change.
- R7: An exception (exc_req) taken while the enable bit is 0 and lpe_en[cur_priv] is 1 copies cur_elp into the saved-ELP bit. While the enable bit is 1, the exception does not touch the bit.
- R8: On mnret_req, the same cycle shows redirect = 1, nxt_pc = exception-PC, and nxt_priv = previous privilege. nxt_virt is the previous-virtualization bit when the previous privilege is not 3, and 0 when it is 3. nxt_elp is the saved-ELP bit if lpe_en[previous privilege] is 1, else 0. From the next cycle on, the enable bit is 1 and the saved-ELP bit is 0.
- R9: When mnret_req and nmi_req are high in the same cycle, the return is performed. A request still held in the following cycle is then taken as an entry.
- R10: A CSR write in a cycle with a return, an accepted RNMI or an exc_req is dropped.
- R11: With no return and no accepted RNMI, redirect is 0 and nxt_pc, nxt_priv, nxt_virt and nxt_elp equal cur_pc, cur_priv, cur_virt and cur_elp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | RNMI request, level |
| nmi_cause | input | XLEN | Cause value recorded on entry |
| mnret_req | input | 1 | Return-from-RNMI strobe |
| exc_req | input | 1 | Synchronous exception being taken this cycle |
| cur_pc | input | XLEN | PC of the current instruction |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization mode |
| cur_elp | input | 1 | Current landing-pad expectation |
| lpe_en | input | 4 | Landing-pad enable, indexed by privilege code |
| rnmi_vec | input | XLEN | RNMI handler address |
| csr_sel | input | 2 | Register select: 0 status, 1 exception PC, 2 cause, 3 none |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_sel |
| redirect | output | 1 | Entry or return is happening this cycle |
| nxt_pc | output | XLEN | Next PC |
| nxt_priv | output | 2 | Next privilege |
| nxt_virt | output | 1 | Next virtualization mode |
| nxt_elp | output | 1 | Next landing-pad expectation |

## Verification
The bench builds the block with XLEN = 32 and NMIE_RST = 1. The 32-bit width leaves nineteen status bits above the implemented fields, so the write-all-ones case shows that they stay zero. A reset value of 1 for the enable bit lets an RNMI be taken in the first cycle after reset. Random sequences mix requests, returns, exceptions and CSR writes across all three legal privileges and every landing-pad enable pattern. This reaches returns where the saved bit is discarded because landing pads are off for the target privilege, and the case where a return and a request arrive in the same cycle.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EPC    = 2'd1,
        SEL_CAUSE  = 2'd2,
        SEL_NONE   = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ENTRY  = 2'd1,
        EV_RETURN = 2'd2,
        EV_EXC    = 2'd3
    } ev_e;

    localparam int STATUS_W  = 16;
    localparam int BIT_NMIE  = 3;
    localparam int BIT_PV    = 7;
    localparam int BIT_PELP  = 9;
    localparam int BIT_PP_LO = 11;
    localparam int BIT_PP_HI = 12;

    typedef struct packed {
        logic  nmie;
        logic  pv;
        logic  pelp;
        priv_e pp;
    } nst_t;

    function automatic logic [STATUS_W-1:0] status_image(nst_t s);
        logic [STATUS_W-1:0] img;
        img                       = '0;
        img[BIT_NMIE]             = s.nmie;
        img[BIT_PV]               = s.pv;
        img[BIT_PELP]             = s.pelp;
        img[BIT_PP_HI:BIT_PP_LO]  = s.pp;
        return img;
    endfunction

    function automatic nst_t status_write(nst_t old, logic [STATUS_W-1:0] wd);
        nst_t n;
        n      = old;
        n.nmie = wd[BIT_NMIE];
        n.pv   = wd[BIT_PV];
        n.pelp = wd[BIT_PELP];
        if (wd[BIT_PP_HI:BIT_PP_LO] != PRIV_RSV)
            n.pp = priv_e'(wd[BIT_PP_HI:BIT_PP_LO]);
        return n;
    endfunction

    function automatic logic lp_on(logic [3:0] lpe, logic [1:0] p);
        return lpe[p];
    endfunction

endpackage

// File: rtl/rnmi_event_seq.sv
module rnmi_event_seq
    import rnmi_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            nmi_req,
    input  logic            mnret_req,
    input  logic            exc_req,
    input  nst_t            st_q,
    input  logic [XLEN-1:0] epc_q,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic            cur_elp,
    input  logic [3:0]      lpe_en,
    input  logic [XLEN-1:0] rnmi_vec,
    output ev_e             ev,
    output logic            redirect,
    output logic [XLEN-1:0] nxt_pc,
    output logic [1:0]      nxt_priv,
    output logic            nxt_virt,
    output logic            nxt_elp
);

    always_comb begin
        if (mnret_req)
            ev = EV_RETURN;
        else if (nmi_req && st_q.nmie)
            ev = EV_ENTRY;
        else if (exc_req)
            ev = EV_EXC;
        else
            ev = EV_NONE;
    end

    always_comb begin
        redirect = 1'b0;
        nxt_pc   = cur_pc;
        nxt_priv = cur_priv;
        nxt_virt = cur_virt;
        nxt_elp  = cur_elp;
        unique case (ev)
            EV_ENTRY: begin
                redirect = 1'b1;
                nxt_pc   = rnmi_vec;
                nxt_priv = PRIV_M;
                nxt_virt = 1'b0;
                nxt_elp  = 1'b0;
            end
            EV_RETURN: begin
                redirect = 1'b1;
                nxt_pc   = epc_q;
                nxt_priv = st_q.pp;
                nxt_virt = (st_q.pp != PRIV_M) ? st_q.pv : 1'b0;
                nxt_elp  = lp_on(lpe_en, st_q.pp) ? st_q.pelp : 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rnmi_status_reg.sv
module rnmi_status_reg
    import rnmi_pkg::*;
#(
    parameter bit NMIE_RST = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  ev_e                 ev,
    input  logic [1:0]          cur_priv,
    input  logic                cur_virt,
    input  logic                cur_elp,
    input  logic                lpe_cur,
    input  logic                we,
    input  logic [STATUS_W-1:0] wdata,
    output nst_t                st_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.nmie <= NMIE_RST;
            st_q.pv   <= 1'b0;
            st_q.pelp <= 1'b0;
            st_q.pp   <= PRIV_M;
        end else begin
            unique case (ev)
                EV_RETURN: begin
                    st_q.nmie <= 1'b1;
                    st_q.pelp <= 1'b0;
                end
                EV_ENTRY: begin
                    st_q.nmie <= 1'b0;
                    st_q.pv   <= cur_virt;
                    st_q.pp   <= priv_e'(cur_priv);
                    if (lpe_cur)
                        st_q.pelp <= cur_elp;
                end
                EV_EXC: begin
                    if (!st_q.nmie && lpe_cur)
                        st_q.pelp <= cur_elp;
                end
                default: begin
                    if (we)
                        st_q <= status_write(st_q, wdata);
                end
            endcase
        end
    end

endmodule

// File: rtl/rnmi_epc_reg.sv
module rnmi_epc_reg
    import rnmi_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  ev_e             ev,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cause_in,
    input  logic            we_epc,
    input  logic            we_cause,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q
);

    localparam logic [XLEN-1:0] EVEN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (ev == EV_ENTRY) begin
            epc_q   <= cur_pc & EVEN_MASK;
            cause_q <= cause_in;
        end else if (ev == EV_NONE) begin
            if (we_epc)
                epc_q <= wdata & EVEN_MASK;
            if (we_cause)
                cause_q <= wdata;
        end
    end

endmodule

// File: rtl/rnmi_ctrl.sv
module rnmi_ctrl
    import rnmi_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit NMIE_RST = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            nmi_req,
    input  logic [XLEN-1:0] nmi_cause,
    input  logic            mnret_req,
    input  logic            exc_req,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic            cur_elp,
    input  logic [3:0]      lpe_en,
    input  logic [XLEN-1:0] rnmi_vec,
    input  logic [1:0]      csr_sel,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            redirect,
    output logic [XLEN-1:0] nxt_pc,
    output logic [1:0]      nxt_priv,
    output logic            nxt_virt,
    output logic            nxt_elp
);

    localparam int PAD_W = XLEN - STATUS_W;

    ev_e             ev;
    nst_t            st_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] cause_q;
    logic            nmie_q;
    logic            pelp_q;
    logic            lpe_cur;
    csr_sel_e        sel;

    assign sel     = csr_sel_e'(csr_sel);
    assign lpe_cur = lp_on(lpe_en, cur_priv);
    assign nmie_q  = st_q.nmie;
    assign pelp_q  = st_q.pelp;

    rnmi_event_seq #(.XLEN(XLEN)) u_seq (
        .nmi_req   (nmi_req),
        .mnret_req (mnret_req),
        .exc_req   (exc_req),
        .st_q      (st_q),
        .epc_q     (epc_q),
        .cur_pc    (cur_pc),
        .cur_priv  (cur_priv),
        .cur_virt  (cur_virt),
        .cur_elp   (cur_elp),
        .lpe_en    (lpe_en),
        .rnmi_vec  (rnmi_vec),
        .ev        (ev),
        .redirect  (redirect),
        .nxt_pc    (nxt_pc),
        .nxt_priv  (nxt_priv),
        .nxt_virt  (nxt_virt),
        .nxt_elp   (nxt_elp)
    );

    rnmi_status_reg #(.NMIE_RST(NMIE_RST)) u_status (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cur_priv (cur_priv),
        .cur_virt (cur_virt),
        .cur_elp  (cur_elp),
        .lpe_cur  (lpe_cur),
        .we       (csr_we && sel == SEL_STATUS),
        .wdata    (csr_wdata[STATUS_W-1:0]),
        .st_q     (st_q)
    );

    rnmi_epc_reg #(.XLEN(XLEN)) u_epc (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cur_pc   (cur_pc),
        .cause_in (nmi_cause),
        .we_epc   (csr_we && sel == SEL_EPC),
        .we_cause (csr_we && sel == SEL_CAUSE),
        .wdata    (csr_wdata),
        .epc_q    (epc_q),
        .cause_q  (cause_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                unique case (sel)
                    SEL_STATUS: csr_rdata = {{PAD_W{1'b0}}, status_image(st_q)};
                    SEL_EPC:    csr_rdata = epc_q;
                    SEL_CAUSE:  csr_rdata = cause_q;
                    default:    csr_rdata = '0;
                endcase
            end
        end else begin : g_nopad
            always_comb begin
                unique case (sel)
                    SEL_STATUS: csr_rdata = status_image(st_q)[XLEN-1:0];
                    SEL_EPC:    csr_rdata = epc_q;
                    SEL_CAUSE:  csr_rdata = cause_q;
                    default:    csr_rdata = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/rnmi_ctrl_chk.sv
module rnmi_ctrl_chk
    import rnmi_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            nmi_req,
    input logic            mnret_req,
    input logic [1:0]      cur_priv,
    input logic            cur_virt,
    input logic [XLEN-1:0] rnmi_vec,
    input logic [1:0]      csr_sel,
    input logic [XLEN-1:0] csr_rdata,
    input logic            redirect,
    input logic [XLEN-1:0] nxt_pc,
    input logic [1:0]      nxt_priv,
    input logic            nxt_virt,
    input logic            nxt_elp,
    input logic            nmie_q,
    input logic            pelp_q
);

    localparam logic [XLEN-1:0] IMPL_MASK = XLEN'(32'h0000_1A88);

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd0) |-> ((csr_rdata & ~IMPL_MASK) == '0));

    p_epc_even_r3: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd1) |-> (csr_rdata[0] == 1'b0));

    p_entry_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && nmie_q && !mnret_req) |->
            (redirect && nxt_pc == rnmi_vec && nxt_priv == 2'd3 && !nxt_virt && !nxt_elp));

    p_entry_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && nmie_q && !mnret_req) |=> !nmie_q);

    p_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !nmie_q && !mnret_req) |-> !redirect);

    p_return_clears_r8: assert property (@(posedge clk) disable iff (rst)
        mnret_req |=> (nmie_q && !pelp_q));

    p_return_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (mnret_req && nmi_req) |-> (redirect && nxt_pc != rnmi_vec || redirect));

    p_quiet_passthru_r11: assert property (@(posedge clk) disable iff (rst)
        (!mnret_req && !(nmi_req && nmie_q)) |->
            (!redirect && nxt_priv == cur_priv && nxt_virt == cur_virt));

endmodule

bind rnmi_ctrl rnmi_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nmi_req   (nmi_req),
    .mnret_req (mnret_req),
    .cur_priv  (cur_priv),
    .cur_virt  (cur_virt),
    .rnmi_vec  (rnmi_vec),
    .csr_sel   (csr_sel),
    .csr_rdata (csr_rdata),
    .redirect  (redirect),
    .nxt_pc    (nxt_pc),
    .nxt_priv  (nxt_priv),
    .nxt_virt  (nxt_virt),
    .nxt_elp   (nxt_elp),
    .nmie_q    (nmie_q),
    .pelp_q    (pelp_q)
);

// File: tb/rnmi_ctrl_test.sv
module rnmi_ctrl_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            nmi_req, mnret_req, exc_req, cur_virt, cur_elp, csr_we;
    logic [XLEN-1:0] nmi_cause, cur_pc, rnmi_vec, csr_wdata, csr_rdata, nxt_pc;
    logic [1:0]      cur_priv, csr_sel, nxt_priv;
    logic [3:0]      lpe_en;
    logic            redirect, nxt_virt, nxt_elp;

    int total = 0;
    int bad   = 0;

    logic            m_nmie, m_pv, m_pelp;
    logic [1:0]      m_pp;
    logic [XLEN-1:0] m_epc, m_cause;

    always #5 clk = ~clk;

    rnmi_ctrl #(.XLEN(XLEN), .NMIE_RST(1'b1)) uut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .nmi_cause(nmi_cause),
        .mnret_req(mnret_req), .exc_req(exc_req), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .cur_elp(cur_elp),
        .lpe_en(lpe_en), .rnmi_vec(rnmi_vec), .csr_sel(csr_sel),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect(redirect), .nxt_pc(nxt_pc), .nxt_priv(nxt_priv),
        .nxt_virt(nxt_virt), .nxt_elp(nxt_elp)
    );

    task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_status();
        logic [XLEN-1:0] v;
        v        = '0;
        v[3]     = m_nmie;
        v[7]     = m_pv;
        v[9]     = m_pelp;
        v[12:11] = m_pp;
        return v;
    endfunction

    function automatic logic [XLEN-1:0] exp_read(logic [1:0] s);
        case (s)
            2'd0:    return exp_status();
            2'd1:    return m_epc;
            2'd2:    return m_cause;
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(logic [1:0] s);
        case (s)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic model_update();
        if (mnret_req) begin
            m_nmie = 1'b1;
            m_pelp = 1'b0;
        end else if (nmi_req && m_nmie) begin
            m_epc   = cur_pc & ~XLEN'(1);
            m_cause = nmi_cause;
            m_pp    = cur_priv;
            m_pv    = cur_virt;
            m_nmie  = 1'b0;
            if (lpe_en[cur_priv]) m_pelp = cur_elp;
        end else if (exc_req) begin
            if (!m_nmie && lpe_en[cur_priv]) m_pelp = cur_elp;
        end else if (csr_we) begin
            case (csr_sel)
                2'd0: begin
                    m_nmie = csr_wdata[3];
                    m_pv   = csr_wdata[7];
                    m_pelp = csr_wdata[9];
                    if (csr_wdata[12:11] != 2'd2) m_pp = csr_wdata[12:11];
                end
                2'd1: m_epc = csr_wdata & ~XLEN'(1);
                2'd2: m_cause = csr_wdata;
                default: ;
            endcase
        end
    endtask

    // drive at negedge, check combinational outputs, then advance one edge
    task automatic step(string tag, logic nr, logic mr, logic ex, logic [XLEN-1:0] pc,
                        logic [1:0] pr, logic vt, logic el, logic [3:0] lp,
                        logic [1:0] sel, logic we, logic [XLEN-1:0] wd);
        logic [XLEN-1:0] e_pc;
        logic [1:0]      e_priv;
        logic            e_red, e_virt, e_elp;
        string           t;
        @(negedge clk);
        nmi_req = nr; mnret_req = mr; exc_req = ex; cur_pc = pc; cur_priv = pr;
        cur_virt = vt; cur_elp = el; lpe_en = lp; csr_sel = sel; csr_we = we;
        csr_wdata = wd; nmi_cause = {pc[15:0], wd[15:0]}; rnmi_vec = 32'h8000_0100;
        #1;
        if (mr) begin
            t = "R8";
            e_red = 1'b1; e_pc = m_epc; e_priv = m_pp;
            e_virt = (m_pp != 2'd3) ? m_pv : 1'b0;
            e_elp = lp[m_pp] ? m_pelp : 1'b0;
        end else if (nr && m_nmie) begin
            t = "R4";
            e_red = 1'b1; e_pc = rnmi_vec; e_priv = 2'd3; e_virt = 1'b0; e_elp = 1'b0;
        end else begin
            t = nr ? "R6" : "R11";
            e_red = 1'b0; e_pc = pc; e_priv = pr; e_virt = vt; e_elp = el;
        end
        if (tag != "") t = tag;
        chk(t, "redirect", XLEN'(redirect), XLEN'(e_red));
        chk(t, "nxt_pc",   nxt_pc, e_pc);
        chk(t, "nxt_priv", XLEN'(nxt_priv), XLEN'(e_priv));
        chk(t, "nxt_virt", XLEN'(nxt_virt), XLEN'(e_virt));
        chk(t, "nxt_elp",  XLEN'(nxt_elp), XLEN'(e_elp));
        chk(read_tag(sel), "csr_rdata", csr_rdata, exp_read(sel));
        @(posedge clk);
        model_update();
    endtask

    task automatic idle_read(string tag, logic [1:0] sel, logic [XLEN-1:0] exp);
        @(negedge clk);
        nmi_req = 0; mnret_req = 0; exc_req = 0; csr_we = 0; csr_sel = sel;
        #1;
        chk(tag, "read", csr_rdata, exp);
    endtask

    function automatic logic [1:0] rnd_priv();
        logic [1:0] p;
        p = 2'($urandom_range(0, 2));
        return (p == 2'd2) ? 2'd3 : p;
    endfunction

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; nmi_req = 0; mnret_req = 0; exc_req = 0; cur_pc = 0; cur_priv = 3;
        cur_virt = 0; cur_elp = 0; lpe_en = 0; rnmi_vec = 0; csr_sel = 0; csr_we = 0;
        csr_wdata = 0; nmi_cause = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_nmie = 1; m_pv = 0; m_pelp = 0; m_pp = 2'd3; m_epc = 0; m_cause = 0;

        // R1 reset values
        idle_read("R1", 2'd0, 32'h0000_1808);
        idle_read("R1", 2'd1, 32'h0);
        idle_read("R1", 2'd2, 32'h0);

        // R2 write all ones, then reserved previous privilege
        step("R2", 0, 0, 0, 32'h100, 2'd3, 0, 0, 4'h0, 2'd0, 1, 32'hFFFF_FFFF);
        idle_read("R2", 2'd0, 32'h0000_1A88);
        step("R2", 0, 0, 0, 32'h100, 2'd3, 0, 0, 4'h0, 2'd0, 1, 32'h0000_1008);
        idle_read("R2", 2'd0, 32'h0000_1808);
        step("R2", 0, 0, 0, 32'h100, 2'd3, 0, 0, 4'h0, 2'd0, 1, 32'h0000_0808);
        idle_read("R2", 2'd0, 32'h0000_0808);

        // R3 odd exception PC written by software
        step("R3", 0, 0, 0, 32'h100, 2'd3, 0, 0, 4'h0, 2'd1, 1, 32'h1234_5677);
        idle_read("R3", 2'd1, 32'h1234_5676);

        // R5 entry from S with landing pads on saves ELP=1
        step("R5", 1, 0, 0, 32'h4000_0013, 2'd1, 1, 1, 4'b0010, 2'd0, 0, 0);
        idle_read("R5", 2'd0, 32'h0000_0A80);
        idle_read("R3", 2'd1, 32'h4000_0012);
        // R6 request ignored while handler runs
        step("R6", 1, 0, 0, 32'h500, 2'd3, 0, 0, 4'hF, 2'd1, 0, 0);
        idle_read("R6", 2'd1, 32'h4000_0012);
        // R8 return restores ELP for S, virt kept
        step("R8", 0, 1, 0, 32'h600, 2'd3, 0, 0, 4'b0010, 2'd0, 0, 0);
        idle_read("R8", 2'd0, 32'h0000_0888);
        // R5 entry from U with landing pads off: bit unchanged (0)
        step("R5", 1, 0, 0, 32'h700, 2'd0, 0, 1, 4'b1110, 2'd0, 0, 0);
        idle_read("R5", 2'd0, 32'h0000_0000);
        // R7 exception inside handler saves ELP
        step("R7", 0, 0, 1, 32'h800, 2'd3, 0, 1, 4'b1000, 2'd0, 0, 0);
        idle_read("R7", 2'd0, 32'h0000_0200);
        // R10 CSR write with a return is dropped; R8 ELP discarded for U
        step("R10", 0, 1, 0, 32'h900, 2'd3, 0, 0, 4'b1110, 2'd2, 1, 32'hDEAD_BEEF);
        idle_read("R10", 2'd2, 32'h0700_0000);
        idle_read("R8", 2'd0, 32'h0000_0008);
        // R7 exception with enable bit set leaves the bit alone
        step("R7", 0, 0, 1, 32'hA00, 2'd3, 0, 1, 4'hF, 2'd0, 0, 0);
        idle_read("R7", 2'd0, 32'h0000_0008);
        // R9 return and request together, request held
        step("R5", 1, 0, 0, 32'hB00, 2'd3, 0, 0, 4'h0, 2'd0, 0, 0);
        step("R9", 1, 1, 0, 32'hC00, 2'd3, 0, 0, 4'h0, 2'd0, 0, 0);
        step("R9", 1, 0, 0, 32'hD04, 2'd1, 0, 0, 4'h0, 2'd1, 0, 0);
        idle_read("R9", 2'd1, 32'h0000_0D04);
        step("R8", 0, 1, 0, 32'hE00, 2'd3, 0, 0, 4'h0, 2'd0, 0, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] pr;
            pr = rnd_priv();
            step("", ($urandom_range(0, 99) < 30), ($urandom_range(0, 99) < 15),
                 ($urandom_range(0, 99) < 15), $urandom, pr,
                 (pr != 2'd3) ? 1'($urandom) : 1'b0, 1'($urandom), 4'($urandom),
                 2'($urandom), ($urandom_range(0, 99) < 25), $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule